// File: doc/BRIEF.md
# Global-History Correlating Direction Predictor

This block guesses whether a conditional branch will be taken. It does this by joining two kinds of information. The first is a global record of how recent branches resolved. The second is the address of the branch being fetched. The record is a shift register holding the last few outcomes. Its current value chooses one of several pattern tables. A slice of the fetch address then chooses one saturating counter inside that table. Because of this, two branches whose outcomes depend on each other can be told apart by the path that led to them.

Fetch logic presents an address on the lookup side and gets back a taken / not-taken bit in the same cycle. It also gets the history value that was used for that lookup, and it carries that value along with the branch down the pipeline. When the branch resolves, the pipeline sends back the address, the real outcome and the carried history. The block adjusts the counter those values select, then shifts the outcome into the global record.

Setting the history length to zero turns the block into a plain address-indexed table of counters.

Top module: `gcorr_pred`

## Requirements
- R1: After reset, every counter holds the weakly-not-taken value: MSB 0 and all other bits 1, which is 01 for 2-bit counters and 011 for 3-bit counters. The history register is 0. As a result, `pred_taken` is 0 for every address and `pred_hist` is 0.
- R2: Each accepted update (`upd_valid`=1) shifts `upd_taken` into history bit 0, moves the older bits up one place and drops the top bit. The new history appears on `pred_hist` in the cycle after the update. In a cycle without an update, the history holds its value.
- R3: An update changes only the counter at table `upd_hist`, entry index of `upd_addr`. The same address under any other history value keeps its prediction. A lookup uses the table chosen by the current history register. Without an update, `pred_taken` for a steady `pred_addr` does not change.
- R4: The entry index is address bits [ALIGN_LSB+IDX_W-1:ALIGN_LSB], which is bits [5:2] by default. Bits below and above that slice have no effect on which counter is used.
- R5: A taken update increments the selected counter. The counter saturates at all ones, so a 2-bit counter at 11 stays at 11.
- R6: A not-taken update decrements the selected counter. The counter saturates at zero.
- R7: `pred_taken` is the MSB of the counter selected by the current history and `pred_addr`. A value of 1 means predict taken.
- R8: When a lookup and an update happen in the same cycle, the lookup sees the counter contents and the history as they were before that update.
- R9: An update is steered by the supplied `upd_hist` value, not by the history register as it stands when the update arrives.
- R10: With HIST_W=0, the block is a single table indexed by address alone and `upd_hist` has no effect. Wider counters, such as CNT_W=3, reset to 011, predict taken from 100 upward and saturate at 111 and 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pred_addr | input | ADDR_W | Fetch address to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | max(HIST_W,1) | Global history used for this lookup |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_hist | input | max(HIST_W,1) | History carried from the branch's lookup |

## Verification
The bench builds two copies of the block. The first uses the default shape: 2 history bits, 2-bit counters and 4 index bits. With only 4 tables of 16 entries, every table and every counter state can be reached and read back in a few updates. This is enough to show table steering by supplied history, address aliasing and saturation at both ends. The second copy uses no history, 3-bit counters and 3 index bits. It exercises the bimodal variant and the n-bit counter threshold and limits, which the 2-bit build cannot reach.

// File: rtl/gcorr_pkg.sv
package gcorr_pkg;

  // Resolved or predicted branch direction.
  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } br_dir_e;

  // Width used for a history port when the history length may be zero.
  function automatic int hist_port_w(input int hist_len);
    return (hist_len > 0) ? hist_len : 1;
  endfunction

endpackage

// File: rtl/gcorr_sat_ctr.sv
module gcorr_sat_ctr
  import gcorr_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  br_dir_e          dir,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_MIN = {CNT_W{1'b0}};
  localparam logic [CNT_W-1:0] WEAK_NT = CNT_MAX >> 1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (dir == DIR_TAKEN) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + ONE;
    end else begin
      if (cnt_q != CNT_MIN) cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= WEAK_NT;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/gcorr_pht.sv
module gcorr_pht
  import gcorr_pkg::*;
#(
  parameter int AW    = 6,
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_idx,
  input  br_dir_e          wr_dir,
  input  logic [AW-1:0]    rd_idx,
  output logic [CNT_W-1:0] rd_cnt
);

  localparam int DEPTH = 1 << AW;

  logic [CNT_W-1:0] cnt [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == AW'(g));

    gcorr_sat_ctr #(
      .CNT_W (CNT_W)
    ) ctr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (hit),
      .dir   (wr_dir),
      .cnt_q (cnt[g])
    );
  end

  // Read side is combinational, so it returns state from before this edge.
  assign rd_cnt = cnt[rd_idx];

endmodule

// File: rtl/gcorr_ghr.sv
module gcorr_ghr #(
  parameter int HIST_W = 2,
  parameter int HW     = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          shift_in,
  output logic [HW-1:0] hist_q
);

  if (HIST_W > 0) begin : g_hist
    logic [HW-1:0] hist_d;

    always_comb begin
      hist_d = (hist_q << 1) | HW'(shift_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_q <= '0;
      end else if (shift_en) begin
        hist_q <= hist_d;
      end
    end
  end else begin : g_nohist
    assign hist_q = '0;
  end

endmodule

// File: rtl/gcorr_index.sv
module gcorr_index #(
  parameter int ADDR_W    = 32,
  parameter int ALIGN_LSB = 2,
  parameter int IDX_W     = 4,
  parameter int HIST_W    = 2,
  parameter int HW        = (HIST_W > 0) ? HIST_W : 1,
  parameter int AW        = HIST_W + IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HW-1:0]     hist,
  output logic [AW-1:0]     idx
);

  logic [IDX_W-1:0] ent;
  assign ent = addr[ALIGN_LSB +: IDX_W];

  // History picks the table (upper bits), address picks the entry.
  if (HIST_W > 0) begin : g_tbl
    assign idx = {hist, ent};
  end else begin : g_flat
    assign idx = ent;
  end

endmodule

// File: rtl/gcorr_pred.sv
module gcorr_pred
  import gcorr_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ALIGN_LSB = 2,
  parameter int IDX_W     = 4,
  parameter int HIST_W    = 2,
  parameter int CNT_W     = 2,
  parameter int HW        = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] pred_addr,
  output logic              pred_taken,
  output logic [HW-1:0]     pred_hist,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  input  logic [HW-1:0]     upd_hist
);

  localparam int TBL_AW = HIST_W + IDX_W;

  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [TBL_AW-1:0] rd_idx, wr_idx;
  logic [CNT_W-1:0]  rd_cnt;
  logic [HW-1:0]     hist_q;

  gcorr_ghr #(
    .HIST_W (HIST_W)
  ) ghr_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .shift_en (upd_valid),
    .shift_in (upd_taken),
    .hist_q   (hist_q)
  );

  gcorr_index #(
    .ADDR_W    (ADDR_W),
    .ALIGN_LSB (ALIGN_LSB),
    .IDX_W     (IDX_W),
    .HIST_W    (HIST_W)
  ) rd_ix_i (
    .addr (pred_addr),
    .hist (hist_q),
    .idx  (rd_idx)
  );

  gcorr_index #(
    .ADDR_W    (ADDR_W),
    .ALIGN_LSB (ALIGN_LSB),
    .IDX_W     (IDX_W),
    .HIST_W    (HIST_W)
  ) wr_ix_i (
    .addr (upd_addr),
    .hist (upd_hist),
    .idx  (wr_idx)
  );

  gcorr_pht #(
    .AW    (TBL_AW),
    .CNT_W (CNT_W)
  ) pht_i (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .wr_en  (upd_valid),
    .wr_idx (wr_idx),
    .wr_dir (br_dir_e'(upd_taken)),
    .rd_idx (rd_idx),
    .rd_cnt (rd_cnt)
  );

  assign pred_taken = rd_cnt[CNT_W-1];
  assign pred_hist  = hist_q;

endmodule

// File: rtl/gcorr_pred_chk.sv
module gcorr_pred_chk #(
  parameter int ADDR_W = 32,
  parameter int HIST_W = 2,
  parameter int HW     = (HIST_W > 0) ? HIST_W : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] pred_addr,
  input logic              pred_taken,
  input logic [HW-1:0]     pred_hist,
  input logic              upd_valid,
  input logic              upd_taken
);

  logic [HW-1:0] exp_shift;
  assign exp_shift = (pred_hist << 1) | HW'(upd_taken);

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_state_chk: assert (pred_taken == 1'b0 && pred_hist == '0)
        else $error("reset state not weakly-not-taken / zero history");
    end
  end

  if (HIST_W > 0) begin : g_shift
    // R2
    hist_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid |=> pred_hist == $past(exp_shift));
  end

  // R2
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> $stable(pred_hist));

  // R3
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> (!$stable(pred_addr) || $stable(pred_taken)));

endmodule

bind gcorr_pred gcorr_pred_chk #(
  .ADDR_W (ADDR_W),
  .HIST_W (HIST_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pred_addr  (pred_addr),
  .pred_taken (pred_taken),
  .pred_hist  (pred_hist),
  .upd_valid  (upd_valid),
  .upd_taken  (upd_taken)
);

// File: tb/gcorr_pred_tb.sv
`timescale 1ns/1ps
module gcorr_pred_tb_top;

  logic clk, rst_n;
  int n_chk, n_err;
  logic done;

  // Default build: 2 history bits, 2-bit counters, 4 index bits.
  logic [31:0] pa_addr, ua_addr;
  logic        pa_taken, ua_valid, ua_taken;
  logic [1:0]  pa_hist, ua_hist;

  // Bimodal build: no history, 3-bit counters, 3 index bits.
  logic [31:0] pb_addr, ub_addr;
  logic        pb_taken, ub_valid, ub_taken;
  logic [0:0]  pb_hist, ub_hist;

  gcorr_pred dut_i (
    .clk (clk), .rst_n (rst_n),
    .pred_addr (pa_addr), .pred_taken (pa_taken), .pred_hist (pa_hist),
    .upd_valid (ua_valid), .upd_addr (ua_addr), .upd_taken (ua_taken),
    .upd_hist (ua_hist)
  );

  gcorr_pred #(.IDX_W(3), .HIST_W(0), .CNT_W(3)) dut_b_i (
    .clk (clk), .rst_n (rst_n),
    .pred_addr (pb_addr), .pred_taken (pb_taken), .pred_hist (pb_hist),
    .upd_valid (ub_valid), .upd_addr (ub_addr), .upd_taken (ub_taken),
    .upd_hist (ub_hist)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic upd_a(input logic [31:0] a, input logic t, input logic [1:0] h);
    @(negedge clk);
    ua_valid = 1'b1; ua_addr = a; ua_taken = t; ua_hist = h;
    @(negedge clk);
    ua_valid = 1'b0;
  endtask

  task automatic peek_a(input logic [31:0] a, output logic p);
    @(negedge clk);
    pa_addr = a;
    #1 p = pa_taken;
  endtask

  // Scratch entry 15 under table 0 absorbs the history-setting updates.
  task automatic set_hist_a(input logic [1:0] h);
    upd_a(32'h3C, h[1], 2'b00);
    upd_a(32'h3C, h[0], 2'b00);
  endtask

  task automatic upd_b(input logic [31:0] a, input logic t, input logic h);
    @(negedge clk);
    ub_valid = 1'b1; ub_addr = a; ub_taken = t; ub_hist = h;
    @(negedge clk);
    ub_valid = 1'b0;
  endtask

  task automatic peek_b(input logic [31:0] a, output logic p);
    @(negedge clk);
    pb_addr = a;
    #1 p = pb_taken;
  endtask

  task automatic t_reset();
    logic p;
    do_reset();
    for (int i = 0; i < 16; i++) begin
      peek_a(32'(i * 4), p);
      chk("R1 reset prediction", p, 0);
    end
    chk("R1 reset history", pa_hist, 0);
    for (int i = 0; i < 8; i++) begin
      peek_b(32'(i * 4), p);
      chk("R10 R1 bimodal reset prediction", p, 0);
    end
  endtask

  task automatic t_history();
    do_reset();
    upd_a(32'h40, 1'b1, 2'b00);
    #1 chk("R2 history after 1", pa_hist, 2'b01);
    upd_a(32'h40, 1'b0, 2'b00);
    #1 chk("R2 history after 1,0", pa_hist, 2'b10);
    upd_a(32'h40, 1'b1, 2'b00);
    #1 chk("R2 history after 1,0,1", pa_hist, 2'b01);
    repeat (3) @(negedge clk);
    #1 chk("R2 history holds when idle", pa_hist, 2'b01);
  endtask

  task automatic t_sat_up();
    logic p;
    do_reset();
    upd_a(32'h0C, 1'b1, 2'b00);
    set_hist_a(2'b00);
    peek_a(32'h0C, p);
    chk("R7 weak-nt plus taken predicts taken", p, 1);
    upd_a(32'h0C, 1'b1, 2'b00);
    upd_a(32'h0C, 1'b1, 2'b00);
    upd_a(32'h0C, 1'b0, 2'b00);
    set_hist_a(2'b00);
    peek_a(32'h0C, p);
    chk("R5 saturated at 11, one not-taken still taken", p, 1);
    upd_a(32'h0C, 1'b0, 2'b00);
    set_hist_a(2'b00);
    peek_a(32'h0C, p);
    chk("R5 R7 two not-taken from 11 predicts not taken", p, 0);
  endtask

  task automatic t_sat_down();
    logic p;
    do_reset();
    upd_a(32'h14, 1'b0, 2'b00);
    upd_a(32'h14, 1'b0, 2'b00);
    upd_a(32'h14, 1'b1, 2'b00);
    set_hist_a(2'b00);
    peek_a(32'h14, p);
    chk("R6 floor at 00 then taken gives 01", p, 0);
    upd_a(32'h14, 1'b1, 2'b00);
    set_hist_a(2'b00);
    peek_a(32'h14, p);
    chk("R6 second taken gives 10", p, 1);
  endtask

  task automatic t_tables();
    logic p;
    do_reset();
    // History register is 00 while updates steer to table 10 (R9).
    upd_a(32'h1C, 1'b1, 2'b10);
    upd_a(32'h1C, 1'b1, 2'b10);
    set_hist_a(2'b10);
    peek_a(32'h1C, p);
    chk("R9 R3 table 10 entry 7 trained", p, 1);
    peek_a(32'h1D, p);
    chk("R4 low bits ignored (01)", p, 1);
    peek_a(32'h1F, p);
    chk("R4 low bits ignored (11)", p, 1);
    peek_a(32'h5C, p);
    chk("R4 upper bits ignored", p, 1);
    peek_a(32'h18, p);
    chk("R4 neighbour entry 6 untouched", p, 0);
    peek_a(32'h2C, p);
    chk("R4 entry 11 untouched", p, 0);
    set_hist_a(2'b00);
    peek_a(32'h1C, p);
    chk("R3 table 00 entry 7 untouched", p, 0);
    set_hist_a(2'b01);
    peek_a(32'h1C, p);
    chk("R3 table 01 entry 7 untouched", p, 0);
    set_hist_a(2'b11);
    peek_a(32'h1C, p);
    chk("R3 table 11 entry 7 untouched", p, 0);
  endtask

  task automatic t_same_cycle();
    logic p;
    do_reset();
    upd_a(32'h08, 1'b1, 2'b01);
    set_hist_a(2'b01);
    @(negedge clk);
    pa_addr = 32'h08;
    ua_valid = 1'b1; ua_addr = 32'h08; ua_taken = 1'b0; ua_hist = 2'b01;
    #1;
    chk("R8 lookup sees pre-update counter", pa_taken, 1);
    chk("R8 lookup sees pre-update history", pa_hist, 2'b01);
    @(negedge clk);
    ua_valid = 1'b0;
    #1 chk("R2 R8 history after same-cycle update", pa_hist, 2'b10);
    set_hist_a(2'b01);
    peek_a(32'h08, p);
    chk("R8 counter decremented by same-cycle update", p, 0);
  endtask

  task automatic t_bimodal();
    logic p;
    do_reset();
    upd_b(32'h04, 1'b1, 1'b1);
    peek_b(32'h04, p);
    chk("R10 011 plus taken predicts taken", p, 1);
    peek_b(32'h24, p);
    chk("R10 R4 alias above 3 index bits", p, 1);
    peek_b(32'h08, p);
    chk("R10 other entry untouched", p, 0);
    repeat (4) upd_b(32'h04, 1'b1, 1'b0);
    repeat (3) upd_b(32'h04, 1'b0, 1'b1);
    peek_b(32'h04, p);
    chk("R10 saturated 111 minus 3 still taken", p, 1);
    chk("R10 history output stays zero", pb_hist, 0);
    upd_b(32'h04, 1'b0, 1'b0);
    peek_b(32'h04, p);
    chk("R10 one more not-taken gives 011", p, 0);
    repeat (5) upd_b(32'h04, 1'b0, 1'b1);
    upd_b(32'h04, 1'b1, 1'b1);
    upd_b(32'h04, 1'b1, 1'b1);
    upd_b(32'h04, 1'b1, 1'b1);
    peek_b(32'h04, p);
    chk("R10 floor 000 plus 3 taken gives 011", p, 0);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b1;
    pa_addr = '0; ua_addr = '0; ua_valid = 1'b0; ua_taken = 1'b0; ua_hist = '0;
    pb_addr = '0; ub_addr = '0; ub_valid = 1'b0; ub_taken = 1'b0; ub_hist = '0;
    #1 rst_n = 1'b0;
    t_reset();
    t_history();
    t_sat_up();
    t_sat_down();
    t_tables();
    t_same_cycle();
    t_bimodal();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule